// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block runs beside an I2C slave byte shifter and maintains the status flags that software polls while it serves the bus. It watches the already-synchronized SCL and SDA lines and detects Start and Stop conditions. It keeps a flag for whichever of the two was seen most recently. It also records whether the last completed byte was an address or data. At an address match it captures the read/write direction and holds it until the transfer window closes. In 10-bit addressing it raises a request to reload the address register. It also tracks whether the shared data buffer holds a byte.

The shifter reports byte completion, address match, not-acknowledge and buffer traffic as single-cycle pulses. This block only turns those pulses and the bus lines into flags. It shifts no bits and drives no line. The clock is the system clock. Reset is synchronous and active high. A low module enable clears every flag.

Top module: `i2c_slave_status`

## Requirements
- R1: A Start is an SDA high-to-low change while SCL was high in both the previous and the current sample. From the next clock edge, start_seen reads 1 and stop_seen reads 0. An SDA change while SCL is low or rising alters neither flag.
- R2: A Stop is an SDA low-to-high change while SCL was high in both samples. From the next edge, stop_seen reads 1 and start_seen reads 0. Both flags hold their values until the opposite condition is detected.
- R3: After reset every output reads 0. The line history is treated as an idle bus (both lines high).
- R4: While enable is low, every output is 0 after the next edge, and bus conditions and pulses are ignored.
- R5: On a byte_done pulse, data_not_addr becomes the inverse of byte_is_addr (1 = data, 0 = address). Without a pulse it holds.
- R6: On an addr_match pulse, rw_dir takes match_rw (1 = read, 0 = write) and holds it.
- R7: A detected Start, a detected Stop or a nack pulse forces rw_dir to 0. This takes priority over an addr_match in the same cycle.
- R8: With ten_bit high, a byte_done pulse with byte_is_addr high sets upd_addr. An addr_wr pulse clears it, and a set in the same cycle wins.
- R9: With ten_bit low, upd_addr never becomes 1.
- R10: A byte_done or tx_load pulse sets buf_full. A buf_read or tx_data_done pulse (the last data bit sent, before the ACK) clears it. A set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable; low clears all flags |
| scl | input | 1 | Synchronized SCL |
| sda | input | 1 | Synchronized SDA |
| ten_bit | input | 1 | 10-bit addressing mode |
| byte_done | input | 1 | Pulse: byte received |
| byte_is_addr | input | 1 | Completed byte was an address byte |
| addr_match | input | 1 | Pulse: own address matched |
| match_rw | input | 1 | R/W bit received with the match |
| nack | input | 1 | Pulse: not-acknowledge seen |
| addr_wr | input | 1 | Pulse: address register written |
| tx_load | input | 1 | Pulse: transmit byte loaded into buffer |
| tx_data_done | input | 1 | Pulse: last transmit data bit shifted out |
| buf_read | input | 1 | Pulse: buffer read by software |
| start_seen | output | 1 | Start was the last condition |
| stop_seen | output | 1 | Stop was the last condition |
| data_not_addr | output | 1 | Last byte was data |
| rw_dir | output | 1 | Captured direction, 1 = read |
| upd_addr | output | 1 | Address register must be reloaded |
| buf_full | output | 1 | Buffer holds a byte |

## Verification
On every cycle the assertions check several things. Start and Stop flags are never both set. A condition is only flagged with SCL high. A detected condition or not-acknowledge leaves the direction at 0. A low enable empties every flag. An address write without a simultaneous set clears the update request. Whether a Start is recognised only for the exact two-sample SCL-high edge pattern cannot be shown by assertions alone. The same holds for the set-over-clear priorities and for the 7-bit mode never raising the update request. The bench shows these by comparing long random bus and pulse streams against its own reference model, plus directed sequences.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_t;

    typedef enum logic [1:0] {
        COND_NONE  = 2'd0,
        COND_START = 2'd1,
        COND_STOP  = 2'd2
    } cond_e;

    typedef struct packed {
        logic start_seen;
        logic stop_seen;
        logic data_not_addr;
        logic rw_dir;
        logic upd_addr;
        logic buf_full;
    } status_t;

    localparam bus_t    BUS_IDLE    = '{scl: 1'b1, sda: 1'b1};
    localparam status_t STATUS_ZERO = '0;

    // SCL must be high in both samples; SDA edge picks the kind.
    function automatic cond_e classify(bus_t prev, bus_t cur);
        cond_e c;
        c = COND_NONE;
        if (prev.scl && cur.scl) begin
            if (prev.sda && !cur.sda)
                c = COND_START;
            else if (!prev.sda && cur.sda)
                c = COND_STOP;
        end
        return c;
    endfunction

    function automatic logic closes_window(cond_e c, logic nack);
        return (c != COND_NONE) || nack;
    endfunction

endpackage

// File: rtl/i2cst_cond_det.sv
module i2cst_cond_det
    import i2cst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  scl,
    input  logic  sda,
    output cond_e cond
);

    bus_t prev_q;
    bus_t cur;

    assign cur = '{scl: scl, sda: sda};

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= BUS_IDLE;
        else
            prev_q <= cur;
    end

    always_comb begin
        if (en)
            cond = classify(prev_q, cur);
        else
            cond = COND_NONE;
    end

    // R1
    cond_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (cond != COND_NONE) |-> scl);

    // R4
    cond_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (cond == COND_NONE));

endmodule

// File: rtl/i2cst_dir_trk.sv
module i2cst_dir_trk
    import i2cst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  cond_e cond,
    input  logic  nack,
    input  logic  addr_match,
    input  logic  match_rw,
    output logic  rw_dir
);

    logic rw_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            rw_q <= 1'b0;
        else if (closes_window(cond, nack))
            rw_q <= 1'b0;
        else if (addr_match)
            rw_q <= match_rw;
    end

    assign rw_dir = rw_q;

    // R7
    dir_close_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (cond != COND_NONE || nack)) |=> !rw_dir);

    // R6
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !addr_match && !nack && cond == COND_NONE) |=> $stable(rw_dir));

endmodule

// File: rtl/i2cst_flags.sv
module i2cst_flags
    import i2cst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  cond_e cond,
    input  logic  ten_bit,
    input  logic  byte_done,
    input  logic  byte_is_addr,
    input  logic  addr_wr,
    input  logic  tx_load,
    input  logic  tx_data_done,
    input  logic  buf_read,
    output logic  start_seen,
    output logic  stop_seen,
    output logic  data_not_addr,
    output logic  upd_addr,
    output logic  buf_full
);

    logic s_q, p_q, da_q, ua_q, bf_q;
    logic ua_set, bf_set, bf_clr;

    assign ua_set = ten_bit && byte_done && byte_is_addr;
    assign bf_set = byte_done || tx_load;
    assign bf_clr = buf_read || tx_data_done;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            s_q  <= 1'b0;
            p_q  <= 1'b0;
            da_q <= 1'b0;
            ua_q <= 1'b0;
            bf_q <= 1'b0;
        end else begin
            case (cond)
                COND_START: begin s_q <= 1'b1; p_q <= 1'b0; end
                COND_STOP:  begin s_q <= 1'b0; p_q <= 1'b1; end
                default:    ;
            endcase
            if (byte_done)
                da_q <= !byte_is_addr;
            if (ua_set)
                ua_q <= 1'b1;
            else if (addr_wr)
                ua_q <= 1'b0;
            if (bf_set)
                bf_q <= 1'b1;
            else if (bf_clr)
                bf_q <= 1'b0;
        end
    end

    assign start_seen    = s_q;
    assign stop_seen     = p_q;
    assign data_not_addr = da_q;
    assign upd_addr      = ua_q;
    assign buf_full      = bf_q;

    // R2
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_seen && stop_seen));

    // R1
    start_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cond == COND_START) |=> (start_seen && !stop_seen));

    // R2
    stop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cond == COND_STOP) |=> (stop_seen && !start_seen));

    // R8
    ua_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_wr && !(ten_bit && byte_done && byte_is_addr)) |=> !upd_addr);

    // R10
    bf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (byte_done || tx_load)) |=> buf_full);

endmodule

// File: rtl/i2c_slave_status.sv
module i2c_slave_status
    import i2cst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic scl,
    input  logic sda,
    input  logic ten_bit,
    input  logic byte_done,
    input  logic byte_is_addr,
    input  logic addr_match,
    input  logic match_rw,
    input  logic nack,
    input  logic addr_wr,
    input  logic tx_load,
    input  logic tx_data_done,
    input  logic buf_read,
    output logic start_seen,
    output logic stop_seen,
    output logic data_not_addr,
    output logic rw_dir,
    output logic upd_addr,
    output logic buf_full
);

    cond_e   cond;
    status_t st;

    i2cst_cond_det u_cond (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .scl  (scl),
        .sda  (sda),
        .cond (cond)
    );

    i2cst_dir_trk u_dir (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .cond       (cond),
        .nack       (nack),
        .addr_match (addr_match),
        .match_rw   (match_rw),
        .rw_dir     (st.rw_dir)
    );

    i2cst_flags u_flags (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .cond          (cond),
        .ten_bit       (ten_bit),
        .byte_done     (byte_done),
        .byte_is_addr  (byte_is_addr),
        .addr_wr       (addr_wr),
        .tx_load       (tx_load),
        .tx_data_done  (tx_data_done),
        .buf_read      (buf_read),
        .start_seen    (st.start_seen),
        .stop_seen     (st.stop_seen),
        .data_not_addr (st.data_not_addr),
        .upd_addr      (st.upd_addr),
        .buf_full      (st.buf_full)
    );

    assign start_seen    = st.start_seen;
    assign stop_seen     = st.stop_seen;
    assign data_not_addr = st.data_not_addr;
    assign rw_dir        = st.rw_dir;
    assign upd_addr      = st.upd_addr;
    assign buf_full      = st.buf_full;

    // R4
    dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == STATUS_ZERO));

endmodule

// File: tb/i2c_slave_status_tb.sv
module i2c_slave_status_tb;

    localparam int PERIOD   = 10;
    localparam int N_RAND   = 4000;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, scl = 1, sda = 1, ten_bit = 0, byte_done = 0, byte_is_addr = 0;
    logic addr_match = 0, match_rw = 0, nack = 0, addr_wr = 0;
    logic tx_load = 0, tx_data_done = 0, buf_read = 0;
    logic start_seen, stop_seen, data_not_addr, rw_dir, upd_addr, buf_full;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state
    logic m_pscl = 1, m_psda = 1;
    logic e_s = 0, e_p = 0, e_da = 0, e_rw = 0, e_ua = 0, e_bf = 0;

    always #(PERIOD/2) clk = ~clk;

    i2c_slave_status u_dut (
        .clk(clk), .rst(rst), .en(en), .scl(scl), .sda(sda), .ten_bit(ten_bit),
        .byte_done(byte_done), .byte_is_addr(byte_is_addr), .addr_match(addr_match),
        .match_rw(match_rw), .nack(nack), .addr_wr(addr_wr), .tx_load(tx_load),
        .tx_data_done(tx_data_done), .buf_read(buf_read),
        .start_seen(start_seen), .stop_seen(stop_seen), .data_not_addr(data_not_addr),
        .rw_dir(rw_dir), .upd_addr(upd_addr), .buf_full(buf_full)
    );

    function automatic logic is_start(logic ps, logic pd, logic s, logic d);
        return ps && s && pd && !d;
    endfunction

    function automatic logic is_stop(logic ps, logic pd, logic s, logic d);
        return ps && s && !pd && d;
    endfunction

    always @(posedge clk) begin
        logic st, sp;
        st = is_start(m_pscl, m_psda, scl, sda);
        sp = is_stop(m_pscl, m_psda, scl, sda);
        if (rst) begin
            m_pscl <= 1'b1; m_psda <= 1'b1;
        end else begin
            m_pscl <= scl; m_psda <= sda;
        end
        if (rst || !en) begin
            e_s <= 0; e_p <= 0; e_da <= 0; e_rw <= 0; e_ua <= 0; e_bf <= 0;
        end else begin
            if (st) begin e_s <= 1; e_p <= 0; end
            else if (sp) begin e_s <= 0; e_p <= 1; end
            if (byte_done) e_da <= !byte_is_addr;
            if (st || sp || nack) e_rw <= 0;
            else if (addr_match) e_rw <= match_rw;
            if (ten_bit && byte_done && byte_is_addr) e_ua <= 1;
            else if (addr_wr) e_ua <= 0;
            if (byte_done || tx_load) e_bf <= 1;
            else if (buf_read || tx_data_done) e_bf <= 0;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_all();
        chk("R1 start_seen", start_seen, e_s);
        chk("R2 stop_seen", stop_seen, e_p);
        chk("R5 data_not_addr", data_not_addr, e_da);
        chk("R6 rw_dir", rw_dir, e_rw);
        chk("R8 upd_addr", upd_addr, e_ua);
        chk("R10 buf_full", buf_full, e_bf);
    endtask

    task automatic clr_pulses();
        byte_done = 0; addr_match = 0; nack = 0; addr_wr = 0;
        tx_load = 0; tx_data_done = 0; buf_read = 0;
    endtask

    // advance one clock, compare at the following falling edge
    task automatic cyc();
        @(negedge clk);
        chk_all();
        clr_pulses();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * WATCHDOG);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R3: reset state
        chk("R3 start_seen", start_seen, 1'b0);
        chk("R3 stop_seen", stop_seen, 1'b0);
        chk("R3 rw_dir", rw_dir, 1'b0);
        chk("R3 buf_full", buf_full, 1'b0);
        rst = 0; en = 1;
        cyc();

        // R1: start condition
        sda = 0; cyc();
        chk("R1 start", start_seen, 1'b1);
        // SDA change with SCL low: no condition
        scl = 0; cyc();
        sda = 1; cyc();
        sda = 0; cyc();
        chk("R1 scl-low ignored", start_seen, 1'b1);
        // R6: address match, read
        addr_match = 1; match_rw = 1; byte_done = 1; byte_is_addr = 1; cyc();
        chk("R6 read", rw_dir, 1'b1);
        chk("R5 addr byte", data_not_addr, 1'b0);
        // R7: nack closes window; same-cycle match loses
        nack = 1; addr_match = 1; match_rw = 1; cyc();
        chk("R7 nack priority", rw_dir, 1'b0);
        // R2: stop condition
        scl = 1; cyc();
        sda = 1; cyc();
        chk("R2 stop", stop_seen, 1'b1);
        chk("R2 start cleared", start_seen, 1'b0);
        // R8 / R9: ten-bit update request
        ten_bit = 0; byte_done = 1; byte_is_addr = 1; cyc();
        chk("R9 7-bit no ua", upd_addr, 1'b0);
        ten_bit = 1; byte_done = 1; byte_is_addr = 1; cyc();
        chk("R8 ua set", upd_addr, 1'b1);
        addr_wr = 1; byte_done = 1; byte_is_addr = 1; cyc();
        chk("R8 set wins", upd_addr, 1'b1);
        addr_wr = 1; cyc();
        chk("R8 ua clear", upd_addr, 1'b0);
        // R10: transmit buffer
        buf_read = 1; cyc();
        tx_load = 1; cyc();
        chk("R10 tx load", buf_full, 1'b1);
        tx_data_done = 1; cyc();
        chk("R10 tx done", buf_full, 1'b0);
        byte_done = 1; byte_is_addr = 0; buf_read = 1; cyc();
        chk("R10 set wins", buf_full, 1'b1);
        chk("R5 data byte", data_not_addr, 1'b1);
        // R4: disable clears and ignores
        en = 0; sda = 0; byte_done = 1; tx_load = 1; cyc();
        chk("R4 bf", buf_full, 1'b0);
        chk("R4 start", start_seen, 1'b0);
        chk("R4 da", data_not_addr, 1'b0);
        en = 1; sda = 1; cyc();

        // Random phase
        for (int i = 0; i < N_RAND; i++) begin
            en           = ($urandom_range(0, 39) != 0);
            if ($urandom_range(0, 2) == 0) scl = ~scl;
            if ($urandom_range(0, 2) == 0) sda = ~sda;
            ten_bit      = ($urandom_range(0, 1) == 1);
            byte_done    = ($urandom_range(0, 4) == 0);
            byte_is_addr = ($urandom_range(0, 1) == 1);
            addr_match   = ($urandom_range(0, 4) == 0);
            match_rw     = ($urandom_range(0, 1) == 1);
            nack         = ($urandom_range(0, 7) == 0);
            addr_wr      = ($urandom_range(0, 5) == 0);
            tx_load      = ($urandom_range(0, 6) == 0);
            tx_data_done = ($urandom_range(0, 5) == 0);
            buf_read     = ($urandom_range(0, 5) == 0);
            cyc();
        end
        summary();
    end

endmodule